// File: doc/BRIEF.md
# Page-Mode EEPROM Write Controller

This block is a clocked model of the control logic of a byte-wide parallel EEPROM with page-mode writes. Three active-low strobes (chip select `ce_n`, output enable `oe_n`, write strobe `we_n`) come from an external bus. A fast system clock samples them through two-flop synchronizers. A write strobe is taken when the chip is selected, the write strobe is low and the output enable is high. The address is latched when that condition starts and the data byte when it ends. The byte goes into a page buffer with one entry per column.

The first byte of a page fixes the row. Later bytes keep that row and supply only their column, so a page can be filled with 1 to 2^COL_W bytes in any order. A load timer restarts after each byte and is held at zero while a strobe is low. When it runs out, an internal programming phase of WRITE_CYC cycles copies the marked page entries into the storage array. During that phase further write strobes are ignored. Reads made while the page is loading or programming return the inverted last loaded byte, so software can poll for completion. The default array is 2^(ROW_W+COL_W) = 2048 bytes. ROW_W = 7 gives the full 8K x 8 organisation.

Top module: `pgeep_ctrl`

## Requirements
- R1: After synchronous reset, `busy` and `dout_en` are 0 and `dout` is 0.
- R2: A byte is accepted only when `ce_n`=0, `we_n`=0 and `oe_n`=1 held together and then ended. Any other strobe combination writes nothing. The address is taken when that condition starts and `din` when it ends. `busy` rises on the third rising clock edge after the release of the first byte of a page is presented.
- R3: A write condition that lasts fewer than MIN_PULSE clock cycles (as seen after synchronization) is ignored. It loads no byte and does not raise `busy`.
- R4: The row bits (addr[ROW_W+COL_W-1:COL_W]) are fixed by the first byte of a page. Every later byte of that page is stored at that row, at its own column (addr[COL_W-1:0]).
- R5: Programming starts LOAD_TMO clock edges after the later of the last accepted byte and the last edge on which a write condition was active. Holding a strobe low therefore extends the page load indefinitely.
- R6: Programming lasts WRITE_CYC clock edges, after which `busy` falls. Write strobes that end during programming are ignored.
- R7: `dout_en` is 1 on the third rising edge after a read condition (`ce_n`=0, `oe_n`=0, `we_n`=1) is presented, and is 0 otherwise. When not busy, `dout` shows the array byte at the address present on the previous rising edge. `dout` is 0 when `dout_en` is 0.
- R8: While `busy` is 1, an enabled read returns the bitwise inverse of the most recently accepted byte, whatever the address.
- R9: Programming changes only the array bytes loaded during that page. All other bytes of the row keep their values.
- R10: A write in which `ce_n` falls last and rises first is handled like one controlled by `we_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | ROW_W+COL_W | Byte address: row in upper bits, column in lower COL_W bits |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or inverted polling byte, 0 when not enabled |
| dout_en | output | 1 | Read data valid |
| busy | output | 1 | High from the first accepted byte until programming ends |

## Verification
Every strobe passes through two synchronizer stages before a registered decision. So `busy` and `dout_en` respond on the third rising edge after the input change, while `dout` follows the address one edge after it changes. The programming start falls LOAD_TMO edges after the last byte or low-strobe edge, and the end of `busy` a further WRITE_CYC edges later. The bench keeps a history of the inputs sampled at each edge and places each event at these offsets in an event-time model. It compares `busy`, `dout_en` and `dout` at every falling edge, so an off-by-one in any latency shows up as a miscompare on a specific cycle.

// File: rtl/pgeep_pkg.sv
package pgeep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pg_state_t;
endpackage

// File: rtl/pgeep_sync.sv
module pgeep_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= 1'b1;
          s2 <= 1'b1;
        end else begin
          s1 <= d[i];
          s2 <= s1;
        end
      end
      assign q[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/pgeep_strobe.sv
module pgeep_strobe #(
  parameter int MIN_PULSE = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_s,
  input  logic oe_s,
  input  logic we_s,
  output logic wr_act,
  output logic wr_rise,
  output logic wr_take,
  output logic rd_cond
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PULSE);

  logic [CNT_W-1:0] cnt;
  logic             act_d;

  assign wr_act  = !ce_s && !we_s && oe_s;
  assign rd_cond = !ce_s && !oe_s && we_s;
  assign wr_rise = wr_act && !act_d;
  assign wr_take = !wr_act && act_d && (cnt == MIN_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      act_d <= 1'b0;
    end else begin
      act_d <= wr_act;
      if (!wr_act)
        cnt <= '0;
      else if (cnt != MIN_C)
        cnt <= cnt + 1'b1;
    end
  end

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_act && cnt == MIN_C) |=> (cnt == MIN_C || !wr_act));
endmodule

// File: rtl/pgeep_page.sv
module pgeep_page #(
  parameter int COL_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [COL_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int PAGE_N = 1 << COL_W;

  logic [DATA_W-1:0] buf_q [PAGE_N];
  logic [PAGE_N-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      valid_q <= '0;
    else if (wr_en)
      valid_q[wr_idx] <= 1'b1;
  end

  assign rd_data  = buf_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  // R9
  mark_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/pgeep_array.sv
module pgeep_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgeep_ctrl.sv
module pgeep_ctrl
  import pgeep_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int COL_W     = 6,
  parameter int ROW_W     = 5,
  parameter int MIN_PULSE = 5,
  parameter int LOAD_TMO  = 40,
  parameter int WRITE_CYC = 100
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [DATA_W-1:0]      din,
  output logic [DATA_W-1:0]      dout,
  output logic                   dout_en,
  output logic                   busy
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PAGE_N = 1 << COL_W;
  localparam int TMR_W  = $clog2(LOAD_TMO + 1);
  localparam int WC_W   = $clog2(WRITE_CYC + 1);
  localparam logic [TMR_W-1:0] TMO_LAST = TMR_W'(LOAD_TMO - 1);
  localparam logic [WC_W-1:0]  WC_LAST  = WC_W'(WRITE_CYC - 1);
  localparam logic [WC_W-1:0]  PAGE_LIM = WC_W'(PAGE_N);

  logic [2:0] strb_s;
  logic       wr_act, wr_rise, wr_take, rd_cond, accept;

  pg_state_t          state;
  logic [TMR_W-1:0]   tmr;
  logic [WC_W-1:0]    wc;
  logic [ADDR_W-1:0]  addr_hold;
  logic [ROW_W-1:0]   row_q;
  logic [DATA_W-1:0]  last_q;
  logic               en_q;
  logic [DATA_W-1:0]  pg_data, rd_q;
  logic               pg_valid, pg_clr, arr_we;

  pgeep_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce_n, oe_n, we_n}),
    .q   (strb_s)
  );

  pgeep_strobe #(.MIN_PULSE(MIN_PULSE)) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .ce_s    (strb_s[2]),
    .oe_s    (strb_s[1]),
    .we_s    (strb_s[0]),
    .wr_act  (wr_act),
    .wr_rise (wr_rise),
    .wr_take (wr_take),
    .rd_cond (rd_cond)
  );

  assign accept = wr_take && (state != ST_PROG);
  assign pg_clr = (state == ST_PROG) && (wc == WC_LAST);
  assign arr_we = (state == ST_PROG) && (wc < PAGE_LIM) && pg_valid;

  pgeep_page #(.COL_W(COL_W), .DATA_W(DATA_W)) u_page (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept),
    .wr_idx   (addr_hold[COL_W-1:0]),
    .wr_data  (din),
    .clr      (pg_clr),
    .rd_idx   (wc[COL_W-1:0]),
    .rd_data  (pg_data),
    .rd_valid (pg_valid)
  );

  pgeep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr ({row_q, wc[COL_W-1:0]}),
    .wdata (pg_data),
    .raddr (addr),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      wc        <= '0;
      addr_hold <= '0;
      row_q     <= '0;
      last_q    <= '0;
      en_q      <= 1'b0;
    end else begin
      en_q <= rd_cond;
      if (wr_rise) addr_hold <= addr;
      if (accept)  last_q    <= din;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_LOAD;
            row_q <= addr_hold[ADDR_W-1:COL_W];
            tmr   <= '0;
          end
        end
        ST_LOAD: begin
          if (accept || wr_act) begin
            tmr <= '0;
          end else if (tmr == TMO_LAST) begin
            state <= ST_PROG;
            wc    <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_PROG: begin
          if (wc == WC_LAST) state <= ST_IDLE;
          else               wc    <= wc + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign dout_en = en_q;
  assign dout    = en_q ? (busy ? ~last_q : rd_q) : '0;

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_take));

  // R4
  row_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(row_q));

  // R5
  load_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_LOAD && state == ST_PROG) |-> !$past(wr_act));

  // R6
  prog_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_PROG && state == ST_IDLE) |-> ($past(wc) == WC_LAST));

  // R6
  prog_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG) |=> (state != ST_LOAD));
endmodule

// File: tb/tb_pgeep_ctrl.sv
`timescale 1ns/1ps
module tb_pgeep_ctrl;
  localparam int DATA_W = 8, COL_W = 6, ROW_W = 5;
  localparam int MIN_PULSE = 5, LOAD_TMO = 40, WRITE_CYC = 100;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PAGE_N = 1 << COL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_en, busy;

  always #2 clk = ~clk;

  pgeep_ctrl #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W),
               .MIN_PULSE(MIN_PULSE), .LOAD_TMO(LOAD_TMO), .WRITE_CYC(WRITE_CYC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  int vec = 0, miss = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  bit hce[4], hoe[4], hwe[4];
  int mem_m [1 << ADDR_W];
  int pg_m [PAGE_N];
  bit pv_m [PAGE_N];
  int mst = 0, run = 0, dl = 0, dn = 0, acap = 0, mrow = 0, mlast = 0;
  bit exp_busy = 0, exp_en = 0;
  int exp_dout = 0;

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem_m[i] = -1;
  end

  function automatic bit act_at(int i);
    return !hce[i] && !hwe[i] && hoe[i];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin hce[i] = 1; hoe[i] = 1; hwe[i] = 1; end
      for (int i = 0; i < PAGE_N; i++) pv_m[i] = 0;
      mst = 0; run = 0; mlast = 0;
      exp_busy = 0; exp_en = 0; exp_dout = 0;
    end else begin
      bit an, ap, take, rc;
      for (int i = 3; i > 0; i--) begin
        hce[i] = hce[i-1]; hoe[i] = hoe[i-1]; hwe[i] = hwe[i-1];
      end
      hce[0] = ce_n; hoe[0] = oe_n; hwe[0] = we_n;
      an = act_at(2);
      ap = act_at(3);
      take = 0;
      if (an) begin
        if (run < MIN_PULSE) run++;
      end else begin
        if (ap && run >= MIN_PULSE) take = 1;
        run = 0;
      end
      if (an && !ap) acap = int'(addr);
      case (mst)
        0: if (take) begin
             mst = 1; mrow = acap / PAGE_N;
             pg_m[acap % PAGE_N] = int'(din); pv_m[acap % PAGE_N] = 1; mlast = int'(din);
             dl = cyc + LOAD_TMO;
           end
        1: if (take) begin
             pg_m[acap % PAGE_N] = int'(din); pv_m[acap % PAGE_N] = 1; mlast = int'(din);
             dl = cyc + LOAD_TMO;
           end else if (an) begin
             dl = cyc + LOAD_TMO;
           end else if (cyc == dl) begin
             mst = 2; dn = cyc + WRITE_CYC;
           end
        default: if (cyc == dn) begin
             for (int i = 0; i < PAGE_N; i++) begin
               if (pv_m[i]) mem_m[mrow * PAGE_N + i] = pg_m[i];
               pv_m[i] = 0;
             end
             mst = 0;
           end
      endcase
      exp_busy = (mst != 0);
      rc = !hce[2] && !hoe[2] && hwe[2];
      exp_en = rc;
      if (!rc)           exp_dout = 0;
      else if (exp_busy) exp_dout = (~mlast) & 8'hFF;
      else               exp_dout = mem_m[addr];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vec++;
      if (busy !== exp_busy) begin
        miss++;
        $display("FAIL %s cyc %0d busy actual %0b expected %0b", cur_req, cyc, busy, exp_busy);
      end else if (dout_en !== exp_en) begin
        miss++;
        $display("FAIL %s cyc %0d dout_en actual %0b expected %0b", cur_req, cyc, dout_en, exp_en);
      end else if (exp_dout >= 0 && dout !== exp_dout[DATA_W-1:0]) begin
        miss++;
        $display("FAIL %s cyc %0d dout actual %02h expected %02h", cur_req, cyc, dout, exp_dout[7:0]);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      miss++;
      $display("FAIL watchdog cyc %0d actual running expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end

  function automatic logic [ADDR_W-1:0] ad(int row, int col);
    return ADDR_W'(row * PAGE_N + col);
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(logic [ADDR_W-1:0] a, logic [7:0] d, int len);
    @(negedge clk);
    addr = a; din = d; oe_n = 1; ce_n = 0; we_n = 0;
    wait_n(len);
    ce_n = 1; we_n = 1;
    wait_n(5);
  endtask

  task automatic wr_byte_ce(logic [ADDR_W-1:0] a, logic [7:0] d, int len);
    @(negedge clk);
    addr = a; din = d; oe_n = 1; we_n = 0;
    @(negedge clk);
    ce_n = 0;
    wait_n(len);
    ce_n = 1;
    wait_n(2);
    we_n = 1;
    wait_n(4);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, int n);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    wait_n(n);
    ce_n = 1; oe_n = 1;
  endtask

  initial begin
    cur_req = "R1";
    wait_n(5);
    rst = 0;
    wait_n(6);

    // R2 / R8: three-byte page with polling reads in between
    cur_req = "R2";
    wr_byte(ad(3, 10), 8'hA5, 8);
    cur_req = "R8";
    rd(ad(20, 1), 8);
    cur_req = "R2";
    wr_byte(ad(3, 2), 8'h3C, 8);
    cur_req = "R8";
    rd(ad(3, 10), 8);
    cur_req = "R2";
    wr_byte(ad(3, 63), 8'h81, 8);
    cur_req = "R8";
    rd(ad(0, 0), 10);
    cur_req = "R6";
    wait_n(160);
    cur_req = "R7";
    rd(ad(3, 10), 8);
    rd(ad(3, 2), 8);
    rd(ad(3, 63), 8);
    wait_n(4);

    // R4: row locked by first byte
    cur_req = "R4";
    wr_byte(ad(7, 5), 8'h11, 8);
    wait_n(160);
    wr_byte(ad(9, 0), 8'h22, 8);
    wr_byte(ad(7, 5), 8'h99, 8);
    wait_n(160);
    rd(ad(7, 5), 8);
    rd(ad(9, 5), 8);
    rd(ad(9, 0), 8);

    // R3: short strobe ignored
    cur_req = "R3";
    wr_byte(ad(3, 10), 8'h00, 2);
    wait_n(60);
    rd(ad(3, 10), 8);

    // R5: extended page load with strobe held low
    cur_req = "R5";
    wr_byte(ad(12, 1), 8'h5A, 8);
    wr_byte(ad(12, 2), 8'h6B, 120);
    wait_n(160);
    rd(ad(12, 1), 8);
    rd(ad(12, 2), 8);

    // R6: write attempt during programming ignored
    cur_req = "R6";
    wr_byte(ad(4, 0), 8'h77, 8);
    wait_n(LOAD_TMO + 10);
    wr_byte(ad(4, 0), 8'h00, 8);
    wait_n(140);
    rd(ad(4, 0), 8);

    // R10: chip-select controlled write
    cur_req = "R10";
    wr_byte_ce(ad(14, 7), 8'hC3, 8);
    wait_n(160);
    rd(ad(14, 7), 8);

    // R2: output enable low inhibits writing
    cur_req = "R2";
    @(negedge clk);
    addr = ad(3, 2); din = 8'hEE; ce_n = 0; we_n = 0; oe_n = 0;
    wait_n(10);
    ce_n = 1; we_n = 1; oe_n = 1;
    wait_n(60);
    rd(ad(3, 2), 8);

    // R9: single-byte page leaves neighbours alone
    cur_req = "R9";
    wr_byte(ad(3, 2), 8'h4D, 8);
    wait_n(160);
    rd(ad(3, 2), 8);
    rd(ad(3, 10), 8);
    rd(ad(3, 63), 8);
    wait_n(6);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule